// File: doc/BRIEF.md
# Privilege Return State Unit

This unit keeps the hart's current privilege level (user, supervisor or machine) together with the status fields that a return from a trap handler consumes and rewrites. These are the two interrupt enables, their saved copies, the two saved-privilege fields and the modify-privilege bit. A one-cycle machine-return or supervisor-return strobe moves the saved privilege into the current privilege. It also restores the matching interrupt enable and resets the saved fields. A CSR write port loads the status word, and saved-privilege values that are not legal are refused.

The unit drives three privilege views. The current privilege also serves instruction fetch. The data-access privilege follows the machine saved-privilege field whenever the modify-privilege bit is set. Any return that lands below machine level clears the modify-privilege bit, so lower-privileged code never inherits redirected loads and stores. A return strobe issued from a level too low to use it leaves all state alone and raises an illegal-instruction flag.

The parameter `HAS_U` selects whether user level exists.

Top module: `priv_ret_unit`

## Requirements
- R1: After reset the current privilege is M (2'b11). The status word is 8'h60: every bit is zero except the machine saved-privilege field, which holds M. The data privilege is M and the illegal flag is low.
- R2: The status word is laid out as {MPRV[7], MPP[6:5], SPP[4], SPIE[3], MPIE[2], SIE[1], MIE[0]}. The privilege encoding is U=00, S=01, M=11, and SPP encodes U=0, S=1. With no return strobe present, a CSR write loads every field on the next clock edge, except where R6 and R10 say otherwise.
- R3: A machine return issued in M sets the privilege to the old MPP, MIE to the old MPIE, and MPIE to 1. It sets MPP to U, or to M when `HAS_U`=0.
- R4: A supervisor return issued in S or M sets the privilege to the level in the old SPP, SIE to the old SPIE, and SPIE to 1. It sets SPP to U, or to S when `HAS_U`=0.
- R5: A return whose target privilege is not M clears MPRV. A machine return whose target is M leaves MPRV unchanged.
- R6: A CSR write of 2'b10 to MPP leaves MPP at its previous value, so MPP never holds 2'b10.
- R7: The data privilege equals MPP while MPRV is 1 and equals the current privilege otherwise. The current privilege, which fetch uses, does not depend on MPRV.
- R8: A machine return issued below M, or a supervisor return issued in U, changes no state and drives the illegal flag high in that same cycle. The flag is low in all other cases.
- R9: When a return strobe and a CSR write occur in the same cycle, the return is carried out and the write is discarded.
- R10: With `HAS_U`=0, MPRV reads 0 and ignores writes, SPP reads 1, and a write of U to MPP leaves MPP unchanged. The reset status word is 8'h70.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mret_i | input | 1 | Machine-return strobe, one cycle |
| sret_i | input | 1 | Supervisor-return strobe, one cycle (ignored when mret_i is high) |
| csr_we_i | input | 1 | Status word write enable |
| csr_wdata_i | input | 8 | Status word write data |
| priv_o | output | 2 | Current privilege, also used for fetch |
| status_o | output | 8 | Status word |
| data_priv_o | output | 2 | Effective privilege for loads and stores |
| illegal_o | output | 1 | Return strobe not permitted at current privilege |

## Verification
The return path is tried with MPP set to S, U and M. These cases separate a return that must clear MPRV from one that must keep it. Supervisor returns are tried from S, and also together with a conflicting write, which exposes any wrong priority between the two. The data-privilege output is observed with MPRV both clear and set, and with different MPP values, so that it cannot be confused with the fetch privilege. Illegal MPP encodings, and returns from levels too low to use them, are checked at the status output and on the flag. A second instance without user level covers the hardwired fields.

// File: rtl/priv_ret_unit.sv
module priv_ret_unit #(
  parameter bit HAS_U = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mret_i,
  input  logic       sret_i,
  input  logic       csr_we_i,
  input  logic [7:0] csr_wdata_i,
  output logic [1:0] priv_o,
  output logic [7:0] status_o,
  output logic [1:0] data_priv_o,
  output logic       illegal_o
);

  localparam logic [1:0] PU  = 2'b00;
  localparam logic [1:0] PS  = 2'b01;
  localparam logic [1:0] PM  = 2'b11;
  localparam logic [1:0] LOW = HAS_U ? PU : PM;
  localparam logic       SPP_RST = !HAS_U;

  logic [1:0] priv, mpp;
  logic       mie, sie, mpie, spie, spp, mprv;

  wire        m_ok   = mret_i && (priv == PM);
  wire        s_ok   = sret_i && !mret_i && (priv != PU);
  wire [1:0]  s_tgt  = spp ? PS : PU;
  wire [1:0]  wr_mpp = csr_wdata_i[6:5];
  wire        mpp_ok = (wr_mpp == PM) || (wr_mpp == PS) || ((wr_mpp == PU) && HAS_U);

  assign illegal_o   = (mret_i && (priv != PM)) || (sret_i && !mret_i && (priv == PU));
  assign priv_o      = priv;
  assign status_o    = {mprv, mpp, spp, spie, mpie, sie, mie};
  assign data_priv_o = mprv ? mpp : priv;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      priv <= PM;
      mpp  <= PM;
      mie  <= 1'b0;
      sie  <= 1'b0;
      mpie <= 1'b0;
      spie <= 1'b0;
      spp  <= SPP_RST;
      mprv <= 1'b0;
    end else if (m_ok) begin
      priv <= mpp;
      mie  <= mpie;
      mpie <= 1'b1;
      mpp  <= LOW;
      if (mpp != PM) mprv <= 1'b0;
    end else if (s_ok) begin
      priv <= s_tgt;
      sie  <= spie;
      spie <= 1'b1;
      spp  <= SPP_RST;
      mprv <= 1'b0;
    end else if (csr_we_i && !mret_i && !sret_i) begin
      mie  <= csr_wdata_i[0];
      sie  <= csr_wdata_i[1];
      mpie <= csr_wdata_i[2];
      spie <= csr_wdata_i[3];
      spp  <= HAS_U ? csr_wdata_i[4] : 1'b1;
      if (mpp_ok) mpp <= wr_mpp;
      mprv <= HAS_U && csr_wdata_i[7];
    end
  end

  AST_MRET_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    m_ok |=> (priv == $past(mpp)) && mpie) else $error("mret target"); // R3

  AST_SRET_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    s_ok |=> (sie == $past(spie)) && spie) else $error("sret enable"); // R4

  AST_DROP_MPRV: assert property (@(posedge clk) disable iff (!rst_n)
    ((m_ok && (mpp != PM)) || s_ok) |=> !mprv) else $error("mprv kept"); // R5

  AST_MPP_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    mpp != 2'b10) else $error("mpp illegal"); // R6

  AST_ILLEGAL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_o |=> $stable(status_o) && $stable(priv_o)) else $error("illegal changed"); // R8

  AST_RET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_we_i && s_ok) |=> (priv == $past(s_tgt))) else $error("write won"); // R9

endmodule

// File: tb/sim_priv_ret_unit.sv
module sim_priv_ret_unit;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mret = 1'b0, sret = 1'b0, we = 1'b0;
  logic [7:0] wd = 8'h00;
  logic [1:0] priv0, dpriv0, priv1, dpriv1;
  logic [7:0] st0, st1;
  logic ill0, ill1;
  int total = 0, bad = 0;

  always #2 clk = ~clk;

  priv_ret_unit #(.HAS_U(1'b1)) u0 (
    .clk(clk), .rst_n(rst_n), .mret_i(mret), .sret_i(sret), .csr_we_i(we),
    .csr_wdata_i(wd), .priv_o(priv0), .status_o(st0), .data_priv_o(dpriv0), .illegal_o(ill0));

  priv_ret_unit #(.HAS_U(1'b0)) u1 (
    .clk(clk), .rst_n(rst_n), .mret_i(mret), .sret_i(sret), .csr_we_i(we),
    .csr_wdata_i(wd), .priv_o(priv1), .status_o(st1), .data_priv_o(dpriv1), .illegal_o(ill1));

  // {mret, sret, we, wdata[8], exp priv[2], exp status[8], exp dpriv[2], exp illegal}
  localparam int NV = 8;
  localparam logic [23:0] VEC [NV] = '{
    {3'b001, 8'h8D, 2'b11, 8'h8D, 2'b00, 1'b0},  // R2 R7
    {3'b001, 8'hAD, 2'b11, 8'hAD, 2'b01, 1'b0},  // R7
    {3'b001, 8'hCD, 2'b11, 8'hAD, 2'b01, 1'b0},  // R6
    {3'b100, 8'h00, 2'b01, 8'h0D, 2'b01, 1'b0},  // R3 R5
    {3'b100, 8'h00, 2'b01, 8'h0D, 2'b01, 1'b1},  // R8
    {3'b010, 8'h00, 2'b00, 8'h0F, 2'b00, 1'b0},  // R4 R5
    {3'b010, 8'h00, 2'b00, 8'h0F, 2'b00, 1'b1},  // R8
    {3'b001, 8'hFF, 2'b00, 8'hFF, 2'b11, 1'b0}   // R7
  };
  localparam string TAG [NV] = '{"R2", "R7", "R6", "R3", "R8", "R4", "R8", "R7"};

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  logic ill_seen0;

  task automatic step(input logic m, input logic s, input logic w, input logic [7:0] d);
    @(negedge clk);
    mret = m; sret = s; we = w; wd = d;
    #1 ill_seen0 = ill0;
    @(posedge clk);
    #1 mret = 1'b0; sret = 1'b0; we = 1'b0;
  endtask

  initial begin
    #40000;
    bad++;
    total++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    #1;
    chk("R1 priv", priv0, 2'b11);
    chk("R1 status", st0, 8'h60);
    chk("R1 dpriv", dpriv0, 2'b11);
    chk("R1 illegal", ill0, 0);
    chk("R10 reset status", st1, 8'h70);

    for (int i = 0; i < NV; i++) begin
      step(VEC[i][23], VEC[i][22], VEC[i][21], VEC[i][20:13]);
      chk({TAG[i], " illegal"}, ill_seen0, VEC[i][0]);
      chk({TAG[i], " priv"}, priv0, VEC[i][12:11]);
      chk({TAG[i], " status"}, st0, VEC[i][10:3]);
      chk({TAG[i], " dpriv"}, dpriv0, VEC[i][2:1]);
    end
    chk("R7 fetch priv ignores MPRV", priv0, 2'b00);

    // Return to M keeps MPRV (R5), then return plus write (R9)
    @(negedge clk); rst_n = 1'b0;
    @(posedge clk); #1 rst_n = 1'b1;
    step(1'b0, 1'b0, 1'b1, 8'hE4);
    chk("R2 write", st0, 8'hE4);
    step(1'b1, 1'b0, 1'b0, 8'h00);
    chk("R5 mprv kept priv", priv0, 2'b11);
    chk("R5 mprv kept status", st0, 8'h85);
    chk("R7 dpriv from MPP", dpriv0, 2'b00);
    step(1'b0, 1'b1, 1'b1, 8'h00);
    chk("R9 priv", priv0, 2'b00);
    chk("R9 status", st0, 8'h0D);
    chk("R9 illegal", ill_seen0, 0);

    // No user level instance (R10)
    @(negedge clk); rst_n = 1'b0;
    @(posedge clk); #1 rst_n = 1'b1;
    step(1'b0, 1'b0, 1'b1, 8'hFF);
    chk("R10 hardwired on write", st1, 8'h7F);
    chk("R10 dpriv", dpriv1, 2'b11);
    step(1'b0, 1'b0, 1'b1, 8'h00);
    chk("R10 MPP=U refused", st1, 8'h70);
    step(1'b1, 1'b0, 1'b0, 8'h00);
    chk("R10 mret priv", priv1, 2'b11);
    chk("R10 mret status", st1, 8'h74);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule